// File: doc/BRIEF.md
# Threshold-Qualified Event Duration Counter

This block measures how long a single long-lived event lasts, for example an outstanding cache miss, and counts that event only when its duration goes beyond a programmable limit. An event opens on a begin strobe and closes on a finish strobe. While the event is open, an internal duration register counts cycles. When the event closes, the block compares the measured duration against a 6-bit threshold. That threshold is multiplied by 2 or by 32, as a scale bit selects.

Some event selections are not subject to the threshold. For those, a mode input makes every closed event count, whatever its length. A count-enable input, driven by the counter-freeze logic, stalls the whole block while it is low. The outputs are a qualified-event count and a one-cycle pulse that marks each increment. The block tracks one event at a time.

Top module: `long_event_qualifier`

## Requirements
- R1: Synchronous active-high reset sets `qual_count` to 0, sets `qual_pulse` low and leaves no event open. A `ev_finish` strobe that arrives after reset with no `ev_begin` before it counts nothing.
- R2: The duration D of an event is the number of rising edges from the edge that samples `ev_begin` to the edge that samples `ev_finish`, counting only edges with `count_en` high. With `thresh_mode` = 1, the event is counted only if D is strictly greater than the scaled threshold. A duration equal to the scaled threshold is not counted.
- R3: The scaled threshold is `thresh_val` × 2 when `thresh_x32` = 0 and `thresh_val` × 32 when `thresh_x32` = 1. Both inputs are read on the edge that samples `ev_finish`.
- R4: With `thresh_mode` = 0, every event that closes is counted, whatever its duration.
- R5: A counted event raises `qual_count` by exactly one, and `qual_pulse` is high for that single cycle. Both change on the first enabled rising edge after the edge that samples `ev_finish`. `qual_count` changes at no other time.
- R6: A threshold of 0 with `thresh_mode` = 1 qualifies every event of duration 1 or more.
- R7: The duration register is 12 bits wide and saturates at 4095 without wrapping. An event longer than 4095 cycles therefore exceeds every scaled threshold.
- R8: While `count_en` is low, the duration, the pending result and `qual_count` all hold. `qual_pulse` stays low, and `ev_begin` and `ev_finish` are ignored.
- R9: An `ev_begin` strobe while an event is open is ignored, and so is an `ev_finish` strobe while no event is open. When both strobes arrive together, an open event closes and the begin is dropped. When no event is open, the event opens and the finish is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| count_en | input | 1 | Enable from the freeze logic; low stalls the block |
| ev_begin | input | 1 | Event begin strobe |
| ev_finish | input | 1 | Event finish strobe |
| thresh_mode | input | 1 | 1: duration-qualified counting, 0: count every event |
| thresh_val | input | THR_W (6) | Threshold before scaling |
| thresh_x32 | input | 1 | Scale select: 0 multiplies by 2, 1 multiplies by 32 |
| qual_count | output | CNT_W (32) | Number of counted events |
| qual_pulse | output | 1 | High for the cycle in which `qual_count` increments |

## Verification
Two functions can fall in the same cycle: the closing of an open event and the arrival of a new begin strobe. The bench provokes this by driving both strobes high in one cycle, once with an event open and once with none open. It then judges the result by whether a later lone finish strobe is counted. A second collision is between a freeze and a result that is still pending. Here `count_en` drops on the cycle right after a closing edge, and the bench checks that the pulse is held back until the enable returns. Throughout, a behavioural reference model runs in parallel and is compared with both outputs on every clock.

// File: rtl/leq_pkg.sv
package leq_pkg;
  localparam int LEQ_THR_W_DEF = 6;
  localparam int LEQ_LO_SH_DEF = 1;
  localparam int LEQ_HI_SH_DEF = 5;
  localparam int LEQ_CNT_W_DEF = 32;

  typedef enum logic [0:0] {
    TRK_IDLE = 1'b0,
    TRK_BUSY = 1'b1
  } trk_state_e;
endpackage

// File: rtl/leq_tracker.sv
module leq_tracker
  import leq_pkg::*;
#(
  parameter int DUR_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             begin_stb,
  input  logic             finish_stb,
  output logic             busy,
  output logic             close_now,
  output logic [DUR_W-1:0] dur
);
  localparam logic [DUR_W-1:0] DUR_MAX = '1;
  localparam logic [DUR_W-1:0] DUR_ONE = DUR_W'(1);

  trk_state_e state_q;
  logic [DUR_W-1:0] dur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TRK_IDLE;
      dur_q   <= '0;
    end else if (en) begin
      unique case (state_q)
        TRK_IDLE: begin
          if (begin_stb) begin
            state_q <= TRK_BUSY;
            dur_q   <= DUR_ONE;
          end
        end
        TRK_BUSY: begin
          if (finish_stb) begin
            state_q <= TRK_IDLE;
          end else if (dur_q != DUR_MAX) begin
            dur_q <= dur_q + DUR_ONE;
          end
        end
        default: state_q <= TRK_IDLE;
      endcase
    end
  end

  assign busy      = (state_q == TRK_BUSY);
  assign close_now = en && busy && finish_stb;
  assign dur       = dur_q;
endmodule

// File: rtl/leq_thr_scale.sv
module leq_thr_scale #(
  parameter int THR_W = 6,
  parameter int LO_SH = 1,
  parameter int HI_SH = 5,
  localparam int SCL_W = THR_W + HI_SH
) (
  input  logic [THR_W-1:0] thr,
  input  logic             use_hi,
  output logic [SCL_W-1:0] scaled
);
  logic [SCL_W-1:0] thr_wide;
  logic [SCL_W-1:0] lo_val;
  logic [SCL_W-1:0] hi_val;

  assign thr_wide = SCL_W'(thr);

  generate
    if (LO_SH == 0) begin : g_lo_plain
      assign lo_val = thr_wide;
    end else begin : g_lo_shift
      assign lo_val = thr_wide << LO_SH;
    end
  endgenerate

  assign hi_val = thr_wide << HI_SH;
  assign scaled = use_hi ? hi_val : lo_val;
endmodule

// File: rtl/leq_judge.sv
module leq_judge #(
  parameter int DUR_W = 12,
  parameter int SCL_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             close_now,
  input  logic             qualify,
  input  logic [DUR_W-1:0] dur,
  input  logic [SCL_W-1:0] limit,
  output logic             hit
);
  logic exceeds;
  logic hit_q;

  assign exceeds = dur > DUR_W'(limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0;
    end else if (en) begin
      hit_q <= close_now && (!qualify || exceeds);
    end
  end

  assign hit = hit_q;
endmodule

// File: rtl/leq_counter.sv
module leq_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             hit,
  output logic [CNT_W-1:0] count,
  output logic             pulse
);
  logic [CNT_W-1:0] count_q;
  logic             pulse_q;
  logic             step;

  assign step = en && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= step;
      if (step) begin
        count_q <= count_q + CNT_W'(1);
      end
    end
  end

  assign count = count_q;
  assign pulse = pulse_q;
endmodule

// File: rtl/long_event_qualifier.sv
module long_event_qualifier
  import leq_pkg::*;
#(
  parameter int THR_W = LEQ_THR_W_DEF,
  parameter int LO_SH = LEQ_LO_SH_DEF,
  parameter int HI_SH = LEQ_HI_SH_DEF,
  parameter int CNT_W = LEQ_CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             count_en,
  input  logic             ev_begin,
  input  logic             ev_finish,
  input  logic             thresh_mode,
  input  logic [THR_W-1:0] thresh_val,
  input  logic             thresh_x32,
  output logic [CNT_W-1:0] qual_count,
  output logic             qual_pulse
);
  localparam int SCL_W = THR_W + HI_SH;
  localparam int DUR_W = SCL_W + 1;

  logic             act_w;
  logic             close_w;
  logic [DUR_W-1:0] dur_w;
  logic [SCL_W-1:0] limit_w;
  logic             hit_w;

  leq_tracker #(.DUR_W(DUR_W)) trk_i (
    .clk       (clk),
    .rst       (rst),
    .en        (count_en),
    .begin_stb (ev_begin),
    .finish_stb(ev_finish),
    .busy      (act_w),
    .close_now (close_w),
    .dur       (dur_w)
  );

  leq_thr_scale #(.THR_W(THR_W), .LO_SH(LO_SH), .HI_SH(HI_SH)) scl_i (
    .thr   (thresh_val),
    .use_hi(thresh_x32),
    .scaled(limit_w)
  );

  leq_judge #(.DUR_W(DUR_W), .SCL_W(SCL_W)) jdg_i (
    .clk      (clk),
    .rst      (rst),
    .en       (count_en),
    .close_now(close_w),
    .qualify  (thresh_mode),
    .dur      (dur_w),
    .limit    (limit_w),
    .hit      (hit_w)
  );

  leq_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk  (clk),
    .rst  (rst),
    .en   (count_en),
    .hit  (hit_w),
    .count(qual_count),
    .pulse(qual_pulse)
  );
endmodule

// File: rtl/leq_checker.sv
module leq_checker #(
  parameter int CNT_W = 32,
  parameter int DUR_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             count_en,
  input logic             ev_begin,
  input logic             ev_finish,
  input logic [CNT_W-1:0] qual_count,
  input logic             qual_pulse,
  input logic             trk_busy,
  input logic [DUR_W-1:0] trk_dur
);
  // R1: reset clears the outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (qual_count == '0 && !qual_pulse));

  // R5: pulse lasts one cycle
  a_r5_pulse_single: assert property (@(posedge clk) disable iff (rst)
    qual_pulse |=> !qual_pulse);

  // R5: pulse goes with a step of exactly one
  a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
    qual_pulse |-> qual_count == $past(qual_count) + CNT_W'(1));

  // R5: no pulse, no change
  a_r5_count_hold: assert property (@(posedge clk) disable iff (rst)
    !qual_pulse |-> $stable(qual_count));

  // R8: freeze suppresses the pulse
  a_r8_freeze_no_pulse: assert property (@(posedge clk) disable iff (rst)
    !count_en |=> !qual_pulse);

  // R8: freeze holds the duration
  a_r8_freeze_dur_hold: assert property (@(posedge clk) disable iff (rst)
    !count_en |=> $stable(trk_dur) && $stable(trk_busy));

  // R7: duration never falls while an event stays open
  a_r7_dur_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (trk_busy && $past(trk_busy)) |-> trk_dur >= $past(trk_dur));

  // R9: begin while open keeps the event open
  a_r9_begin_ignored: assert property (@(posedge clk) disable iff (rst)
    (count_en && trk_busy && ev_begin && !ev_finish) |=> trk_busy);
endmodule

bind long_event_qualifier leq_checker #(.CNT_W(CNT_W), .DUR_W(DUR_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .count_en  (count_en),
  .ev_begin  (ev_begin),
  .ev_finish (ev_finish),
  .qual_count(qual_count),
  .qual_pulse(qual_pulse),
  .trk_busy  (act_w),
  .trk_dur   (dur_w)
);

// File: tb/long_event_qualifier_tb_top.sv
`timescale 1ns/1ps
module long_event_qualifier_tb_top;
  localparam int CNT_W = 32;
  localparam int DMAX  = 4095;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic count_en = 1'b1;
  logic ev_begin = 1'b0;
  logic ev_finish = 1'b0;
  logic thresh_mode = 1'b1;
  logic [5:0] thresh_val = 6'd0;
  logic thresh_x32 = 1'b0;
  logic [CNT_W-1:0] qual_count;
  logic qual_pulse;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit model_on = 1'b0;

  always #2.5 clk = ~clk;

  long_event_qualifier dut_i (
    .clk(clk), .rst(rst), .count_en(count_en), .ev_begin(ev_begin),
    .ev_finish(ev_finish), .thresh_mode(thresh_mode), .thresh_val(thresh_val),
    .thresh_x32(thresh_x32), .qual_count(qual_count), .qual_pulse(qual_pulse)
  );

  // behavioural reference
  bit m_act, m_hit, m_pulse;
  int m_dur;
  logic [CNT_W-1:0] m_cnt;

  always @(posedge clk) begin
    bit nh;
    int lim;
    if (rst) begin
      m_act = 0; m_dur = 0; m_hit = 0; m_pulse = 0; m_cnt = '0;
    end else if (count_en) begin
      m_pulse = m_hit;
      if (m_hit) m_cnt = m_cnt + 1;
      nh = 0;
      lim = int'(thresh_val) * (thresh_x32 ? 32 : 2);
      if (m_act) begin
        if (ev_finish) begin
          nh = thresh_mode ? (m_dur > lim) : 1'b1;
          m_act = 0;
        end else if (m_dur < DMAX) begin
          m_dur = m_dur + 1;
        end
      end else if (ev_begin) begin
        m_act = 1;
        m_dur = 1;
      end
      m_hit = nh;
    end else begin
      m_pulse = 0;
    end
  end

  always @(negedge clk) begin
    if (model_on && !done) begin
      total++;
      if (qual_count !== m_cnt || qual_pulse !== m_pulse) begin
        bad++;
        $display("FAIL R5 model: count=%0d pulse=%0b expected count=%0d pulse=%0b",
                 qual_count, qual_pulse, m_cnt, m_pulse);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setup(bit mode, int thr, bit x32);
    thresh_mode = mode;
    thresh_val  = 6'(thr);
    thresh_x32  = x32;
  endtask

  // event whose finish is sampled d enabled edges after its begin
  task automatic run_event(int d);
    ev_begin = 1'b1;
    tick();
    ev_begin = 1'b0;
    repeat (d - 1) tick();
    ev_finish = 1'b1;
    tick();
    ev_finish = 1'b0;
    repeat (3) tick();
  endtask

  task automatic event_delta(string tag, int d, int exp);
    longint base;
    base = longint'(qual_count);
    run_event(d);
    chk(tag, longint'(qual_count) - base, exp);
  endtask

  task automatic finish_sum();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_sum();
  end

  initial begin
    longint base;
    repeat (3) tick();
    rst = 1'b0;
    model_on = 1'b1;
    tick();
    chk("R1 reset count", qual_count, 0);
    chk("R1 reset pulse", qual_pulse, 0);

    // R1: finish with nothing open
    ev_finish = 1'b1; tick(); ev_finish = 1'b0; repeat (3) tick();
    chk("R1 lone finish after reset", qual_count, 0);

    // R2 boundary: limit 10
    setup(1, 5, 0);
    event_delta("R2 equal not counted", 10, 0);
    event_delta("R2 one above counted", 11, 1);
    event_delta("R2 below not counted", 3, 0);

    // R3 scale
    setup(1, 2, 1);
    event_delta("R3 x32 equal 64", 64, 0);
    event_delta("R3 x32 above 65", 65, 1);
    setup(1, 2, 0);
    event_delta("R3 x2 above 4", 5, 1);

    // R4 unqualified mode
    setup(0, 63, 1);
    event_delta("R4 mode0 short event", 1, 1);

    // R6 zero threshold
    setup(1, 0, 0);
    event_delta("R6 zero limit d1", 1, 1);

    // R5 timing
    setup(1, 0, 1);
    base = longint'(qual_count);
    ev_begin = 1'b1; tick(); ev_begin = 1'b0; tick();
    ev_finish = 1'b1; tick(); ev_finish = 1'b0;
    chk("R5 no pulse at closing edge", qual_pulse, 0);
    chk("R5 count unchanged at closing edge", longint'(qual_count) - base, 0);
    tick();
    chk("R5 pulse next edge", qual_pulse, 1);
    chk("R5 count step", longint'(qual_count) - base, 1);
    tick();
    chk("R5 pulse one cycle", qual_pulse, 0);

    // R7 saturation
    setup(1, 63, 1);
    event_delta("R7 long event saturates", 4200, 1);

    // R8 freeze inside an event: enabled duration 10, limit 10
    setup(1, 5, 0);
    base = longint'(qual_count);
    ev_begin = 1'b1; tick(); ev_begin = 1'b0;
    repeat (4) tick();
    count_en = 1'b0;
    repeat (40) tick();
    count_en = 1'b1;
    repeat (5) tick();
    ev_finish = 1'b1; tick(); ev_finish = 1'b0; repeat (3) tick();
    chk("R8 frozen cycles not measured", longint'(qual_count) - base, 0);

    // R8 freeze with a result pending
    setup(1, 0, 0);
    base = longint'(qual_count);
    ev_begin = 1'b1; tick(); ev_begin = 1'b0;
    ev_finish = 1'b1; tick(); ev_finish = 1'b0;
    count_en = 1'b0;
    repeat (10) begin
      tick();
      chk("R8 pulse held while frozen", qual_pulse, 0);
    end
    chk("R8 count held while frozen", longint'(qual_count) - base, 0);
    count_en = 1'b1;
    repeat (3) tick();
    chk("R8 pending result after freeze", longint'(qual_count) - base, 1);

    // R8 strobes ignored while frozen
    base = longint'(qual_count);
    count_en = 1'b0;
    ev_begin = 1'b1; tick(); ev_begin = 1'b0; tick();
    count_en = 1'b1; tick();
    ev_finish = 1'b1; tick(); ev_finish = 1'b0; repeat (3) tick();
    chk("R8 begin ignored while frozen", longint'(qual_count) - base, 0);

    // R9 begin while open ignored: limit 10, true duration 11
    setup(1, 5, 0);
    base = longint'(qual_count);
    ev_begin = 1'b1; tick(); ev_begin = 1'b0;
    repeat (4) tick();
    ev_begin = 1'b1; tick(); ev_begin = 1'b0;
    repeat (5) tick();
    ev_finish = 1'b1; tick(); ev_finish = 1'b0; repeat (3) tick();
    chk("R9 restart ignored", longint'(qual_count) - base, 1);

    // R9 both strobes while open: close wins
    setup(1, 0, 0);
    base = longint'(qual_count);
    ev_begin = 1'b1; tick(); ev_begin = 1'b0;
    repeat (2) tick();
    ev_begin = 1'b1; ev_finish = 1'b1; tick();
    ev_begin = 1'b0; ev_finish = 1'b0; repeat (3) tick();
    ev_finish = 1'b1; tick(); ev_finish = 1'b0; repeat (3) tick();
    chk("R9 collision open closes", longint'(qual_count) - base, 1);

    // R9 both strobes while idle: open wins
    base = longint'(qual_count);
    ev_begin = 1'b1; ev_finish = 1'b1; tick();
    ev_begin = 1'b0; ev_finish = 1'b0; repeat (3) tick();
    chk("R9 collision idle opens", longint'(qual_count) - base, 0);
    ev_finish = 1'b1; tick(); ev_finish = 1'b0; repeat (3) tick();
    chk("R9 collision idle later close", longint'(qual_count) - base, 1);

    repeat (4) tick();
    finish_sum();
  end
endmodule